// File: doc/BRIEF.md
# Host Bus Endpoint Buffer Port

This block is the slave side of a 16-bit SRAM-style bus through which an external processor reaches a bank of internal endpoint buffers and a few control and status registers. Each bus cycle starts with an address phase qualified by an active-low address strobe. The latched address picks either a register or a buffer window. A buffer window is a single address; every data access to it moves that buffer's own word pointer by one.

The internal side marks a buffer as ready and gives it a direction. The host then moves one full buffer of words, either writing into it or reading out of it, and the ready flag drops on the final word. The host learns that work is pending in one of two ways, selected by a configuration bit. In DMA mode an active-low request line stays low while any buffer is ready, and buffer accesses count only while the host holds the active-low acknowledge low. In interrupt mode a maskable, write-one-to-clear event register drives an active-low interrupt line. In both modes the host reads the status register to find out which buffer needs service.

All bus inputs are sampled on the block clock. The address is latched on any clock edge that sees the strobe low (synchronous mode), or on the edge where the strobe is first seen high again (asynchronous mode).

Top module: `ep_host_port`

## Requirements
- R1: After reset, drq_n_o and irq_n_o are 1, dq_oe_o is 0, and the configuration, status, event and mask registers all read 0.
- R2: dq_oe_o is 1 exactly while cs_n_i and oe_n_i are both 0.
- R3: With configuration bit 1 at 0, the address is latched on every clock edge where adv_n_i is 0. With it at 1, the address is latched on the edge where adv_n_i is 1 and was 0 on the edge before, taking addr_i as it is on that edge.
- R4: A write commits once per strobe, on the first edge with cs_n_i and we_n_i both 0, however long they stay low. A read from a buffer window advances that buffer's pointer once, on the edge where cs_n_i or oe_n_i is first seen high after the read.
- R5: Address map: 0x00 configuration (bit 0 = interrupt mode, bit 1 = asynchronous address latch); 0x01 status, read-only, ready flags in bits 7:0 and direction flags in bits 15:8; 0x02 event register, write-one-to-clear, bits 7:0; 0x03 mask register, bits 7:0, where 1 blocks that event from the interrupt; 0x80+b is the data window of buffer b (b = 0..7). Other addresses read 0 and ignore writes.
- R6: A pulse on int_rdy_set_i[b] sets ready flag b, loads direction flag b from int_rdy_dir_i[b] (1 = host reads, 0 = host writes), sets the word pointer of buffer b to 0, and sets event bit b.
- R7: Ready flag b clears when the 64th word of buffer b is transferred in its direction. No other event clears a ready flag.
- R8: In DMA mode (configuration bit 0 = 0), drq_n_o is 0 exactly while at least one ready flag is set, and irq_n_o is 1.
- R9: In DMA mode, a buffer-window access is accepted only while dack_n_i is 0. Without it, nothing is written and no pointer moves. In interrupt mode dack_n_i is ignored.
- R10: In interrupt mode, irq_n_o is 0 exactly while some event bit is set whose mask bit is 0, and drq_n_o is 1.
- R11: Writing 1s to the event register clears those bits. A set from int_rdy_set_i in the same cycle wins over the clear.
- R12: Words read from a buffer come back in the order and with the values they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; all bus inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Host address |
| dq_i | input | 16 | Host write data |
| dq_o | output | 16 | Read data toward the pad |
| dq_oe_o | output | 1 | Pad drive enable for dq_o |
| cs_n_i | input | 1 | Chip select, active low |
| adv_n_i | input | 1 | Address strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| we_n_i | input | 1 | Write enable, active low |
| irq_n_o | output | 1 | Interrupt to host, active low |
| drq_n_o | output | 1 | DMA request to host, active low |
| dack_n_i | input | 1 | DMA acknowledge from host, active low |
| int_rdy_set_i | input | 8 | Internal side: per-buffer ready pulse |
| int_rdy_dir_i | input | 8 | Internal side: direction for each ready pulse |

## Verification
The bound checker watches the cycle-level rules on every clock. It checks that the data pad is never driven while chip select is high, and that a ready pulse always leaves the matching ready and event bits set on the next cycle. It checks that a ready flag only falls right after an accepted buffer access, that pointers stay frozen in DMA mode while acknowledge is high, and that the request line stays high in interrupt mode. The bench's model tracks both request lines on every cycle. Only the bench scenarios can show the rest: the 64-word count that ends a transfer, the single commit per held write strobe, data coming back in order, the two ways of latching the address, and a simultaneous set and clear of one event bit.

// File: rtl/ep_host_pkg.sv
`timescale 1ns/1ps
package ep_host_pkg;
  typedef enum logic [1:0] {
    REG_CFG  = 2'd0,
    REG_STAT = 2'd1,
    REG_EVT  = 2'd2,
    REG_MASK = 2'd3
  } reg_idx_e;

  typedef struct packed {
    logic async_mode;  // bit 1
    logic irq_mode;    // bit 0
  } cfg_t;
endpackage

// File: rtl/ep_host_front.sv
`timescale 1ns/1ps
module ep_host_front #(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              async_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              adv_n_i,
  input  logic              cs_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_ev_o,
  output logic              rd_ev_o
);
  logic              adv_q;
  logic              wr_idle_q;
  logic              rd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              latch;

  // async: take the address on the strobe's trailing edge
  assign latch = async_i ? (!adv_q && adv_n_i) : !adv_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adv_q     <= 1'b1;
      wr_idle_q <= 1'b1;
      rd_q      <= 1'b0;
      addr_q    <= '0;
    end else begin
      adv_q     <= adv_n_i;
      wr_idle_q <= cs_n_i | we_n_i;
      rd_q      <= !(cs_n_i | oe_n_i);
      if (latch) addr_q <= addr_i;
    end
  end

  assign addr_o  = addr_q;
  assign wr_ev_o = !(cs_n_i | we_n_i) && wr_idle_q;
  assign rd_ev_o = rd_q && (cs_n_i | oe_n_i);
endmodule

// File: rtl/ep_host_regs.sv
`timescale 1ns/1ps
module ep_host_regs
  import ep_host_pkg::*;
#(
  parameter int NB     = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ev_i,
  input  logic              sel_i,
  input  reg_idx_e          idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NB-1:0]     evt_set_i,
  output cfg_t              cfg_o,
  output logic [NB-1:0]     mask_o,
  output logic [NB-1:0]     evt_o
);
  cfg_t          cfg_q;
  logic [NB-1:0] mask_q;
  logic [NB-1:0] evt_q;
  logic          reg_wr;
  logic [NB-1:0] evt_clr;

  assign reg_wr  = wr_ev_i && sel_i;
  assign evt_clr = (reg_wr && idx_i == REG_EVT) ? wdata_i[NB-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      mask_q <= '0;
      evt_q  <= '0;
    end else begin
      if (reg_wr) begin
        case (idx_i)
          REG_CFG:  cfg_q  <= cfg_t'(wdata_i[1:0]);
          REG_MASK: mask_q <= wdata_i[NB-1:0];
          default: ;
        endcase
      end
      // set has priority over clear
      evt_q <= (evt_q & ~evt_clr) | evt_set_i;
    end
  end

  assign cfg_o  = cfg_q;
  assign mask_o = mask_q;
  assign evt_o  = evt_q;
endmodule

// File: rtl/ep_host_bufs.sv
`timescale 1ns/1ps
module ep_host_bufs #(
  parameter int NB     = 8,
  parameter int DEPTH  = 64,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(NB),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ev_i,
  input  logic              rd_ev_i,
  input  logic              sel_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NB-1:0]     set_i,
  input  logic [NB-1:0]     dir_i,
  output logic [NB-1:0]     ready_o,
  output logic [NB-1:0]     dir_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NB*PTR_W-1:0] ptr_o,
  output logic              acc_o
);
  logic [DATA_W-1:0] mem_q [NB*DEPTH];
  logic [PTR_W-1:0]  cur_ptr;
  logic              wr_hit;

  assign cur_ptr = ptr_o[idx_i*PTR_W +: PTR_W];
  assign wr_hit  = sel_i && accept_i && wr_ev_i;
  assign acc_o   = sel_i && accept_i && (wr_ev_i || rd_ev_i);

  always_ff @(posedge clk_i) begin
    if (wr_hit) mem_q[{idx_i, cur_ptr}] <= wdata_i;
  end

  assign rdata_o = mem_q[{idx_i, cur_ptr}];

  for (genvar b = 0; b < NB; b++) begin : g_buf
    logic             hit, w_hit, r_hit, last, done;
    logic [PTR_W-1:0] ptr_q;
    logic             ready_q, dir_q;

    assign hit   = sel_i && accept_i && (idx_i == IDX_W'(b));
    assign w_hit = hit && wr_ev_i;
    assign r_hit = hit && rd_ev_i;
    assign last  = ptr_q == PTR_W'(DEPTH - 1);
    // final word moved in the buffer's own direction
    assign done  = last && ready_q && ((w_hit && !dir_q) || (r_hit && dir_q));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q   <= '0;
        ready_q <= 1'b0;
        dir_q   <= 1'b0;
      end else if (set_i[b]) begin
        ptr_q   <= '0;
        ready_q <= 1'b1;
        dir_q   <= dir_i[b];
      end else if (w_hit || r_hit) begin
        ptr_q <= last ? '0 : ptr_q + 1'b1;
        if (done) ready_q <= 1'b0;
      end
    end

    assign ptr_o[b*PTR_W +: PTR_W] = ptr_q;
    assign ready_o[b] = ready_q;
    assign dir_o[b]   = dir_q;
  end
endmodule

// File: rtl/ep_host_port.sv
`timescale 1ns/1ps
module ep_host_port
  import ep_host_pkg::*;
#(
  parameter int NUM_BUF   = 8,
  parameter int BUF_DEPTH = 64,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  dq_i,
  output logic [DATA_W-1:0]  dq_o,
  output logic               dq_oe_o,
  input  logic               cs_n_i,
  input  logic               adv_n_i,
  input  logic               oe_n_i,
  input  logic               we_n_i,
  output logic               irq_n_o,
  output logic               drq_n_o,
  input  logic               dack_n_i,
  input  logic [NUM_BUF-1:0] int_rdy_set_i,
  input  logic [NUM_BUF-1:0] int_rdy_dir_i
);
  localparam int IDX_W = $clog2(NUM_BUF);
  localparam int PTR_W = $clog2(BUF_DEPTH);

  logic [ADDR_W-1:0]        addr_q;
  logic                     wr_ev, rd_ev;
  logic                     win_sel, reg_sel;
  reg_idx_e                 reg_idx;
  cfg_t                     cfg_q;
  logic                     irq_mode;
  logic [NUM_BUF-1:0]       mask_q, evt_q, ready_q, dir_q;
  logic [NUM_BUF*PTR_W-1:0] ptr_flat;
  logic [DATA_W-1:0]        buf_rdata, reg_rdata;
  logic                     buf_acc;
  logic                     accept;

  ep_host_front #(.ADDR_W(ADDR_W)) u_front (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (cfg_q.async_mode),
    .addr_i  (addr_i),
    .adv_n_i (adv_n_i),
    .cs_n_i  (cs_n_i),
    .oe_n_i  (oe_n_i),
    .we_n_i  (we_n_i),
    .addr_o  (addr_q),
    .wr_ev_o (wr_ev),
    .rd_ev_o (rd_ev)
  );

  assign win_sel  = addr_q[ADDR_W-1] && (addr_q[ADDR_W-2:IDX_W] == '0);
  assign reg_sel  = !addr_q[ADDR_W-1] && (addr_q[ADDR_W-2:2] == '0);
  assign reg_idx  = reg_idx_e'(addr_q[1:0]);
  assign irq_mode = cfg_q.irq_mode;
  assign accept   = irq_mode || !dack_n_i;

  ep_host_regs #(.NB(NUM_BUF), .DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ev_i   (wr_ev),
    .sel_i     (reg_sel),
    .idx_i     (reg_idx),
    .wdata_i   (dq_i),
    .evt_set_i (int_rdy_set_i),
    .cfg_o     (cfg_q),
    .mask_o    (mask_q),
    .evt_o     (evt_q)
  );

  ep_host_bufs #(.NB(NUM_BUF), .DEPTH(BUF_DEPTH), .DATA_W(DATA_W)) u_bufs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_ev_i  (wr_ev),
    .rd_ev_i  (rd_ev),
    .sel_i    (win_sel),
    .idx_i    (addr_q[IDX_W-1:0]),
    .accept_i (accept),
    .wdata_i  (dq_i),
    .set_i    (int_rdy_set_i),
    .dir_i    (int_rdy_dir_i),
    .ready_o  (ready_q),
    .dir_o    (dir_q),
    .rdata_o  (buf_rdata),
    .ptr_o    (ptr_flat),
    .acc_o    (buf_acc)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      case (reg_idx)
        REG_CFG:  reg_rdata = DATA_W'(cfg_q);
        REG_STAT: reg_rdata = DATA_W'({dir_q, ready_q});
        REG_EVT:  reg_rdata = DATA_W'(evt_q);
        REG_MASK: reg_rdata = DATA_W'(mask_q);
        default:  reg_rdata = '0;
      endcase
    end
  end

  assign dq_o    = win_sel ? buf_rdata : reg_rdata;
  assign dq_oe_o = !cs_n_i && !oe_n_i;
  assign drq_n_o = !(!irq_mode && (ready_q != '0));
  assign irq_n_o = !(irq_mode && ((evt_q & ~mask_q) != '0));
endmodule

// File: rtl/ep_host_port_chk.sv
`timescale 1ns/1ps
module ep_host_port_chk #(
  parameter int NB    = 8,
  parameter int PTR_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_n_i,
  input logic             dack_n_i,
  input logic             dq_oe_o,
  input logic             drq_n_o,
  input logic             irq_mode,
  input logic             buf_acc,
  input logic [NB-1:0]    int_rdy_set_i,
  input logic [NB-1:0]    ready_q,
  input logic [NB-1:0]    evt_q,
  input logic [NB*PTR_W-1:0] ptr_flat
);
  // R2
  oe_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |-> !dq_oe_o);

  // R6
  rdy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_rdy_set_i != '0) |=> ((ready_q & $past(int_rdy_set_i)) == $past(int_rdy_set_i)));

  // R11
  evt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_rdy_set_i != '0) |=> ((evt_q & $past(int_rdy_set_i)) == $past(int_rdy_set_i)));

  // R7
  rdy_clear_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(ready_q) & ~ready_q) != '0) |-> $past(buf_acc));

  // R9
  no_dack_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_mode && dack_n_i && int_rdy_set_i == '0) |=> $stable(ptr_flat));

  // R10
  irq_mode_drq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_mode |-> drq_n_o);
endmodule

bind ep_host_port ep_host_port_chk #(.NB(NUM_BUF), .PTR_W(PTR_W)) u_chk (.*);

// File: tb/ep_host_port_tb_top.sv
`timescale 1ns/1ps
module ep_host_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic        cs_n = 1'b1, adv_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic        irq_n, drq_n;
  logic        dack_n = 1'b1;
  logic [7:0]  rdy_set = '0, rdy_dir = '0;

  int checks = 0;
  int errors = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  // reference model state
  int         m_mem [8][64];
  int         m_ptr [8];
  logic [7:0] m_ready = '0, m_dir = '0, m_evt = '0, m_mask = '0;
  logic       m_irq = 1'b0, m_async = 1'b0;

  always #2.5 clk = ~clk;

  ep_host_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .dq_i(dq_in), .dq_o(dq_out),
    .dq_oe_o(dq_oe), .cs_n_i(cs_n), .adv_n_i(adv_n), .oe_n_i(oe_n), .we_n_i(we_n),
    .irq_n_o(irq_n), .drq_n_o(drq_n), .dack_n_i(dack_n),
    .int_rdy_set_i(rdy_set), .int_rdy_dir_i(rdy_dir)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_drq();
    return !(!m_irq && (m_ready != '0));
  endfunction

  function automatic logic exp_irq();
    return !(m_irq && ((m_evt & ~m_mask) != '0));
  endfunction

  // per-cycle comparison of request lines
  always @(negedge clk) begin
    if (mon_en && !done) begin
      chk("R8 drq", {31'b0, drq_n}, {31'b0, exp_drq()});
      chk("R10 irq", {31'b0, irq_n}, {31'b0, exp_irq()});
    end
  end

  function automatic logic [15:0] exp_rd(input logic [7:0] a);
    if (a[7] && a[6:3] == '0) return 16'(m_mem[a[2:0]][m_ptr[a[2:0]]]);
    if (a[7:2] == '0) begin
      case (a[1:0])
        2'd0: return {14'b0, m_async, m_irq};
        2'd1: return {m_dir, m_ready};
        2'd2: return {8'b0, m_evt};
        default: return {8'b0, m_mask};
      endcase
    end
    return 16'h0;
  endfunction

  task automatic model_acc(input logic [7:0] a, input bit is_wr, input logic [15:0] d);
    int  b;
    bit  last;
    if (!(a[7] && a[6:3] == '0)) return;
    if (!(m_irq || !dack_n)) return;
    b = int'(a[2:0]);
    if (is_wr) m_mem[b][m_ptr[b]] = int'(d);
    last = (m_ptr[b] == 63);
    if (last && m_ready[b] && (m_dir[b] != is_wr)) m_ready[b] = 1'b0;
    m_ptr[b] = last ? 0 : m_ptr[b] + 1;
  endtask

  task automatic model_reg_wr(input logic [7:0] a, input logic [15:0] d);
    if (a[7:2] != '0) return;
    case (a[1:0])
      2'd0: begin m_irq = d[0]; m_async = d[1]; end
      2'd2: m_evt = m_evt & ~d[7:0];
      2'd3: m_mask = d[7:0];
      default: ;
    endcase
  endtask

  task automatic model_set(input logic [7:0] sv, input logic [7:0] dv);
    for (int b = 0; b < 8; b++) begin
      if (sv[b]) begin
        m_ready[b] = 1'b1;
        m_dir[b]   = dv[b];
        m_ptr[b]   = 0;
        m_evt[b]   = 1'b1;
      end
    end
  endtask

  task automatic addr_ph(input logic [7:0] a);
    @(negedge clk); adv_n = 1'b0; addr = a;
    @(posedge clk);
    @(negedge clk); adv_n = 1'b1;
    @(posedge clk);
  endtask

  // strobe low for two edges, address changes as strobe rises
  task automatic slide(input logic [7:0] a0, input logic [7:0] a1);
    @(negedge clk); adv_n = 1'b0; addr = a0;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk); adv_n = 1'b1; addr = a1;
    @(posedge clk);
  endtask

  task automatic host_wr(input logic [7:0] a, input logic [15:0] d,
                         input logic [7:0] sv, input int hold);
    addr_ph(a);
    @(negedge clk); cs_n = 1'b0; we_n = 1'b0; dq_in = d; rdy_set = sv;
    @(posedge clk); #1;
    if (a[7]) model_acc(a, 1'b1, d); else model_reg_wr(a, d);
    model_set(sv, rdy_dir);
    @(negedge clk); rdy_set = '0;
    repeat (hold) @(posedge clk);
    @(negedge clk); cs_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd_cycle(input logic [7:0] a, input string req);
    logic [15:0] e;
    e = exp_rd(a);
    @(negedge clk); cs_n = 1'b0; oe_n = 1'b0;
    #1;
    chk("R2 oe on read", {31'b0, dq_oe}, 32'd1);
    chk(req, {16'b0, dq_out}, {16'b0, e});
    @(posedge clk);
    @(negedge clk); oe_n = 1'b1; cs_n = 1'b1;
    @(posedge clk); #1;
    model_acc(a, 1'b0, 16'h0);
  endtask

  task automatic host_rd(input logic [7:0] a, input string req);
    addr_ph(a);
    rd_cycle(a, req);
  endtask

  task automatic int_set(input logic [7:0] sv, input logic [7:0] dv);
    @(negedge clk); rdy_set = sv; rdy_dir = dv;
    @(posedge clk); #1;
    model_set(sv, dv);
    @(negedge clk); rdy_set = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++) m_ptr[b] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; mon_en = 1'b1;

    // R1 reset state
    #1;
    chk("R1 drq", {31'b0, drq_n}, 32'd1);
    chk("R1 irq", {31'b0, irq_n}, 32'd1);
    chk("R1 oe", {31'b0, dq_oe}, 32'd0);
    for (int r = 0; r < 4; r++) host_rd(8'(r), "R1 reg");

    // R2 pad enable needs both strobes
    @(negedge clk); cs_n = 1'b1; oe_n = 1'b0; #1;
    chk("R2 cs high", {31'b0, dq_oe}, 32'd0);
    @(negedge clk); cs_n = 1'b0; oe_n = 1'b1; #1;
    chk("R2 oe high", {31'b0, dq_oe}, 32'd0);
    @(negedge clk); cs_n = 1'b1;

    // R6 ready pulse, buffer 2 host-write
    int_set(8'h04, 8'h00);
    host_rd(8'h01, "R6 status");
    host_rd(8'h02, "R6 event");
    chk("R8 drq low", {31'b0, drq_n}, 32'd0);

    // R9 write without acknowledge is dropped
    dack_n = 1'b1;
    host_wr(8'h82, 16'hDEAD, 8'h00, 0);
    dack_n = 1'b0;
    for (int i = 0; i < 63; i++) host_wr(8'h82, 16'hA500 + 16'(i), 8'h00, 0);
    chk("R9 still ready after 63", {31'b0, drq_n}, 32'd0);
    host_rd(8'h01, "R7 ready before last");
    host_wr(8'h82, 16'hA53F, 8'h00, 0);
    chk("R7 drq released", {31'b0, drq_n}, 32'd1);
    host_rd(8'h01, "R7 ready cleared");

    // R12 read back; buffer 5 also made ready
    int_set(8'h24, 8'h04);
    host_rd(8'h01, "R6 two ready");
    for (int i = 0; i < 64; i++) host_rd(8'h82, "R12 data");
    chk("R8 drq held by buf5", {31'b0, drq_n}, 32'd0);
    host_rd(8'h01, "R7 buf2 done");

    // R10 interrupt mode
    host_wr(8'h00, 16'h0001, 8'h00, 0);
    chk("R10 drq off", {31'b0, drq_n}, 32'd1);
    chk("R10 irq on", {31'b0, irq_n}, 32'd0);
    host_wr(8'h02, 16'h0004, 8'h00, 0);
    host_rd(8'h02, "R11 w1c partial");
    host_wr(8'h02, 16'h0020, 8'h00, 0);
    chk("R10 irq off", {31'b0, irq_n}, 32'd1);

    // mask
    host_wr(8'h03, 16'h0008, 8'h00, 0);
    int_set(8'h08, 8'h00);
    chk("R10 masked", {31'b0, irq_n}, 32'd1);
    host_rd(8'h02, "R10 masked event visible");
    int_set(8'h10, 8'h00);
    chk("R10 unmasked", {31'b0, irq_n}, 32'd0);
    // R11 same-cycle set and clear
    host_wr(8'h02, 16'h0010, 8'h10, 0);
    host_rd(8'h02, "R11 set wins");
    host_wr(8'h02, 16'h0018, 8'h00, 0);
    chk("R11 cleared", {31'b0, irq_n}, 32'd1);

    // R4 held write strobe commits once; dack ignored in irq mode (R9)
    dack_n = 1'b1;
    host_wr(8'h83, 16'h1111, 8'h00, 3);
    for (int i = 0; i < 62; i++) host_wr(8'h83, 16'h2000 + 16'(i), 8'h00, 0);
    host_rd(8'h01, "R4 ready after 63");
    host_wr(8'h83, 16'h2FFF, 8'h00, 0);
    host_rd(8'h01, "R4 ready after 64");

    // R3 sync latch keeps last low-strobe address
    slide(8'h03, 8'h00);
    rd_cycle(8'h03, "R3 sync latch");
    host_wr(8'h00, 16'h0003, 8'h00, 0);
    slide(8'h03, 8'h00);
    rd_cycle(8'h00, "R3 async latch");
    host_rd(8'h03, "R3 async plain");

    // R5 read-only status, unmapped address
    host_wr(8'h01, 16'hFFFF, 8'h00, 0);
    host_rd(8'h01, "R5 status read-only");
    host_wr(8'h40, 16'h00FF, 8'h00, 0);
    host_rd(8'h40, "R5 unmapped reads zero");
    host_rd(8'h03, "R5 mask untouched");

    done = 1'b1;
    repeat (2) @(posedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule